// File: doc/BRIEF.md
# Idle-Timed Automatic Sleep Controller

This block watches the command traffic of a storage device controller. When a command finishes and no new command follows within a programmable idle interval, it raises a sleep flag. The power manager uses that flag to put the controller into a low-power state. The interval is held in a writable register. Its reset value is derived from the clock frequency parameter so that it equals 5 ms.

A command that arrives while the controller is asleep wakes it directly. No reset sequence is needed. In the same cycle, the block emits a single-cycle wake request. It then holds a busy indication for a fixed number of cycles so that reads and writes wait until the core is ready again. That number of cycles is derived from a parameter, and its default equals 2.5 ms. The host never has to do anything beyond issuing commands. The idle timer runs only between a command completion and the next command.

Top module: `auto_sleep_ctl`

## Requirements
- R1: While reset is low, and on the first cycle after it, the block reports sleep_flag=0, wake_req=0 and wake_busy=0. Reset also abandons any sleep or countdown in progress.
- R2: The idle timer runs only after a completion. Without a completion since reset, or while a command is issued but not yet complete, sleep_flag stays 0 for any number of cycles.
- R3: The completion strobe is sampled at clock edge E. If no command strobe follows, sleep_flag rises after edge E+D, where D is the idle-delay register value.
- R4: The idle-delay register resets to CLK_HZ*IDLE_US/1e6 cycles. With the default IDLE_US this is 5 ms.
- R5: A cycle with dly_we=1 loads dly_wdata into the idle-delay register, and later countdowns use that value. A value of 0 behaves as 1.
- R6: A command strobe while sleep_flag=1 drives wake_req high combinationally in that cycle. sleep_flag is 0 after the next edge, with no reset involved.
- R7: wake_req is high for only the first cycle of a command strobe held across several cycles. A command strobe while awake gives no wake_req.
- R8: wake_busy goes high on the edge that ends sleep. It stays high for exactly WAKE_CYC = CLK_HZ*WAKE_US/1e6 cycles, which is 2.5 ms by default.
- R9: A command strobe in the same cycle as the timer expiry wins, and sleep is not entered.
- R10: A command strobe during a countdown cancels it. No sleep follows until a new completion has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_issue | input | 1 | Command-issued strobe |
| cmd_done | input | 1 | Command-complete strobe |
| dly_we | input | 1 | Write enable of the idle-delay register |
| dly_wdata | input | DLY_W | New idle delay in clock cycles |
| sleep_flag | output | 1 | High while the controller is asleep |
| wake_req | output | 1 | One-cycle wake request |
| wake_busy | output | 1 | High while waking, before read or write may start |

## Verification
A new command and the end of the idle countdown can fall in the same cycle. To provoke this, the bench sets a short delay, sends a completion and idles for one cycle less than the delay. It then raises the command strobe on the very cycle the timer expires. The bench judges the outcome as correct only if wake_req stays low in that cycle and sleep_flag is still 0 after the edge, because the block never entered sleep. A second overlap is a held command strobe while asleep. There the wake pulse must not repeat while wake_busy counts down.

// File: rtl/auto_sleep_ctl.sv
module auto_sleep_ctl #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned IDLE_US = 5000,
  parameter int unsigned WAKE_US = 2500,
  parameter int unsigned DLY_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_issue,
  input  logic             cmd_done,
  input  logic             dly_we,
  input  logic [DLY_W-1:0] dly_wdata,
  output logic             sleep_flag,
  output logic             wake_req,
  output logic             wake_busy
);

  localparam logic [63:0] IDLE_CYC64 = (64'(CLK_HZ) * 64'(IDLE_US)) / 64'd1_000_000;
  localparam logic [63:0] WAKE_CYC64 = (64'(CLK_HZ) * 64'(WAKE_US)) / 64'd1_000_000;
  localparam int unsigned WAKE_CYC = int'(WAKE_CYC64);
  localparam int unsigned WK_W     = $clog2(WAKE_CYC + 2);
  localparam logic [DLY_W-1:0] DEF_IDLE = DLY_W'(IDLE_CYC64);
  localparam logic [WK_W-1:0]  WK_LOAD  = WK_W'(WAKE_CYC);

  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] idle_cnt;
  logic [WK_W-1:0]  wk_cnt;
  logic             armed;
  logic             expire;

  assign expire    = armed && !sleep_flag &&
                     ({1'b0, idle_cnt} + 1'b1 >= {1'b0, dly_q});
  assign wake_req  = cmd_issue && sleep_flag;
  assign wake_busy = (wk_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) dly_q <= DEF_IDLE;
    else if (dly_we) dly_q <= dly_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      idle_cnt   <= '0;
      sleep_flag <= 1'b0;
    end else if (cmd_issue) begin
      armed      <= 1'b0;
      idle_cnt   <= '0;
      sleep_flag <= 1'b0;
    end else if (cmd_done) begin
      armed      <= 1'b1;
      idle_cnt   <= '0;
    end else if (expire) begin
      armed      <= 1'b0;
      idle_cnt   <= '0;
      sleep_flag <= 1'b1;
    end else if (armed) begin
      idle_cnt   <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wk_cnt <= '0;
    else if (wake_req) wk_cnt <= WK_LOAD;
    else if (wk_cnt != '0) wk_cnt <= wk_cnt - 1'b1;
  end

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req) else $error("wake_req wider than one cycle"); // R7
  AST_CMD_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> !sleep_flag) else $error("asleep after command"); // R6
  AST_BUSY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> wake_busy) else $error("no busy after wake"); // R8
  AST_SLEEP_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> $past(!cmd_issue && armed)) else $error("sleep without countdown"); // R9
  AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_flag |-> !wake_req) else $error("wake pulse while awake"); // R7

endmodule

// File: tb/sim_auto_sleep_ctl.sv
module sim_auto_sleep_ctl;
  localparam int CLK_PER = 10;
  localparam int DW = 16;
  localparam int NV = 7;
  localparam int VEC [0:NV-1][0:2] = '{
    '{3, 2, 0}, '{3, 3, 1}, '{1, 1, 1}, '{0, 1, 1},
    '{7, 6, 0}, '{7, 7, 1}, '{12, 12, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_issue = 1'b0, cmd_done = 1'b0, dly_we = 1'b0;
  logic [DW-1:0] dly_wdata = '0;
  logic sleep_flag, wake_req, wake_busy;
  logic last_wake;
  int total = 0, bad = 0, ncyc = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  auto_sleep_ctl #(.CLK_HZ(2000), .IDLE_US(5000), .WAKE_US(2500), .DLY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_done(cmd_done),
    .dly_we(dly_we), .dly_wdata(dly_wdata), .sleep_flag(sleep_flag),
    .wake_req(wake_req), .wake_busy(wake_busy));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic i, input logic d);
    cmd_issue = i; cmd_done = d;
    #1 last_wake = wake_req;
    @(negedge clk);
    cmd_issue = 1'b0; cmd_done = 1'b0; dly_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 5000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", ncyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (2) @(negedge clk);
    chk("R1 sleep in reset", sleep_flag, 0);
    chk("R1 busy in reset", wake_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wake after reset", wake_req, 0);

    prev = 0;
    for (int v = 0; v < NV; v++) begin
      cyc(1'b1, 1'b0);
      chk("R6/R7 wake pulse on issue", last_wake, prev);
      dly_we = 1'b1; dly_wdata = DW'(VEC[v][0]);
      cyc(1'b0, 1'b0);
      cyc(1'b0, 1'b1);
      idle(VEC[v][1]);
      chk("R3/R5 sleep after delay", sleep_flag, VEC[v][2]);
      prev = VEC[v][2];
    end

    cyc(1'b1, 1'b0);
    chk("R6 wake pulse", last_wake, 1);
    chk("R6 awake after edge", sleep_flag, 0);
    chk("R8 busy starts", wake_busy, 1);
    cyc(1'b1, 1'b0);
    chk("R7 no repeat pulse", last_wake, 0);
    cyc(1'b1, 1'b0);
    chk("R7 no repeat pulse 2", last_wake, 0);
    idle(2);
    chk("R8 busy at 5th cycle", wake_busy, 1);
    idle(1);
    chk("R8 busy ends", wake_busy, 0);
    idle(40);
    chk("R2 no sleep while executing", sleep_flag, 0);

    dly_we = 1'b1; dly_wdata = DW'(4);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    idle(3);
    cyc(1'b1, 1'b0);
    chk("R9 collision no pulse", last_wake, 0);
    chk("R9 collision stays awake", sleep_flag, 0);
    idle(20);
    chk("R9 awake later", sleep_flag, 0);
    cyc(1'b0, 1'b1);
    idle(2);
    cyc(1'b1, 1'b0);
    idle(10);
    chk("R10 cancel countdown", sleep_flag, 0);

    cyc(1'b0, 1'b1);
    idle(4);
    chk("R3 asleep before reset", sleep_flag, 1);
    rst_n = 1'b0;
    idle(2);
    chk("R1 reset wakes", sleep_flag, 0);
    chk("R1 reset busy", wake_busy, 0);
    rst_n = 1'b1;
    idle(30);
    chk("R2 no completion no sleep", sleep_flag, 0);
    cyc(1'b0, 1'b1);
    idle(9);
    chk("R4 default not yet", sleep_flag, 0);
    idle(1);
    chk("R4 default 10 cycles", sleep_flag, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule